// File: doc/BRIEF.md
# Two-Wire Register Slave for a 256-Step Wiper Control

This block is the serial front end of a digitally set potentiometer. It listens on a two-wire bus (SCL clock, SDA data) through a sampled copy of both lines. It sees bus START, repeated START and STOP events and shifts bytes in on SCL rising edges. It answers one fixed 7-bit device address. When addressed, it moves bytes between the bus and a small register bank held in flip-flops. SDA is driven open-drain: the block only ever pulls the line low, through an output-enable pin.

The bank holds several registers:
- an 8-bit wiper position, which drives the tap selection;
- a start-up position register that stands in for stored data;
- five general-purpose bytes;
- a fixed identification byte;
- a one-bit access-control flag.

The access-control flag decides which of the two position registers appears at address 00h. Each register applies its own acknowledge rule. A busy input from the storage sequencer and an active-low write-protect input both withhold acknowledges, so a host can poll for completion and cannot alter protected storage.

A host writes by sending the device address with the write bit, a register address, then data bytes. It reads either by setting the address and issuing a repeated START, or by reading straight on from where the last access stopped. A register pointer steps forward after every data byte.

Top module: `wpot_i2c_slave`

## Requirements
- R1: The address byte 50h (device address 28h, bit 0 = 0 for write) and 51h (bit 0 = 1 for read) are acknowledged. Any other address byte is not acknowledged, and the slave leaves SDA released until the next START. SDA is never driven while the bus is idle.
- R2: While busy_i is high, even a matching address byte gets no acknowledge.
- R3: A register-address byte of 00h–06h or 08h is acknowledged and loads the pointer. A value of 07h, or any value above 08h, is not acknowledged.
- R4: At 08h (control), a data byte always loads its bit 7 into the control flag. The byte is acknowledged only when it is 00h or 80h. A read of 08h returns the flag in bit 7 with zeros below.
- R5: When the flag is 0, a write to 00h sets both the wiper and the start-up register, and a read of 00h returns the start-up register. When the flag is 1, a write to 00h sets only the wiper, and a read returns the wiper.
- R6: Address 01h reads D0h. A write to it is acknowledged and changes nothing.
- R7: Addresses 02h–06h store general-purpose bytes, which reset to 00h. Address 07h reads FFh when a sequential read passes through it.
- R8: The pointer advances by one after every data byte that is written and acknowledged, and after every byte read. It wraps from 08h to 00h.
- R9: A read that starts without a register-address phase begins at the pointer left by the previous access, which is the last address accessed plus one.
- R10: With wp_n_i low, a data byte aimed at storage is not acknowledged and not stored. Storage means 02h–06h, or 00h with the flag at 0. Writes to the wiper (flag at 1) and to the control flag are still accepted.
- R11: After any byte the slave does not acknowledge, it ignores the bus until the next START or STOP. A host no-acknowledge after a read byte ends the transfer.
- R12: After reset, the wiper and the start-up register both hold 80h, the flag is 0 and SDA is released. wiper_o always shows the wiper register.
- R13: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line as seen at the pad) |
| busy_i | input | 1 | Storage sequencer busy; blocks all acknowledges of the device address |
| wp_n_i | input | 1 | Write protect, active low; blocks writes to storage registers |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| wiper_o | output | 8 | Current wiper tap position |

## Verification
The bench builds the block with its default parameters: device address 28h, identification byte D0h, position reset 80h and two synchronizer stages. With these, the master model can address the slave with the same byte values a host would send. Its bit periods are a few system clocks long, so the synchronizer and edge detector delay SDA turn-around by about three clocks. That delay leaves room to check the enable stays quiet while SCL is high. The directed scenarios cover the control-flag remap of address 00h, the pointer wrapping through the reserved FFh slot, write protect acting differently on the wiper and on storage, and a refused byte followed by one that must be dropped.

// File: rtl/wpot_pkg.sv
package wpot_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 4;
    localparam int unsigned NUM_GP = 5;

    localparam logic [PTR_W-1:0] A_MAIN     = PTR_W'(0);
    localparam logic [PTR_W-1:0] A_ID       = PTR_W'(1);
    localparam logic [PTR_W-1:0] A_GP_FIRST = PTR_W'(2);
    localparam logic [PTR_W-1:0] A_GP_LAST  = PTR_W'(int'(A_GP_FIRST) + NUM_GP - 1);
    localparam logic [PTR_W-1:0] A_RSVD     = PTR_W'(int'(A_GP_LAST) + 1);
    localparam logic [PTR_W-1:0] A_CTRL     = PTR_W'(int'(A_GP_LAST) + 2);

    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_IGNORE
    } bus_state_t;

    typedef enum logic [1:0] {
        K_DEV, K_MEM, K_DATA
    } rx_kind_t;

    typedef struct packed {
        logic ack;
        logic wr_wiper;
        logic wr_ivr;
        logic wr_gp;
        logic wr_vol;
    } wr_plan_t;

    // Decide acknowledge and register updates for one incoming data byte.
    function automatic wr_plan_t plan_write(logic [PTR_W-1:0] a, logic [BYTE_W-1:0] d,
                                            logic vol, logic wp_n);
        wr_plan_t p;
        p = '0;
        if (a == A_MAIN) begin
            if (vol) begin
                p.ack = 1'b1; p.wr_wiper = 1'b1;
            end else if (wp_n) begin
                p.ack = 1'b1; p.wr_wiper = 1'b1; p.wr_ivr = 1'b1;
            end
        end else if (a == A_ID) begin
            p.ack = 1'b1;
        end else if (a == A_CTRL) begin
            p.wr_vol = 1'b1;
            p.ack    = (d[BYTE_W-2:0] == '0);
        end else if (a >= A_GP_FIRST && a <= A_GP_LAST && wp_n) begin
            p.ack = 1'b1; p.wr_gp = 1'b1;
        end
        return p;
    endfunction

    function automatic logic addr_ok(logic [BYTE_W-1:0] a);
        return (a <= BYTE_W'(A_CTRL)) && (a != BYTE_W'(A_RSVD));
    endfunction

    function automatic logic [PTR_W-1:0] next_ptr(logic [PTR_W-1:0] p);
        return (p == A_CTRL) ? '0 : p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/wpot_bus_mon.sv
module wpot_bus_mon #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_lvl;
            sda_q    <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_sync[SYNC_STAGES-1];
    assign sda_lvl   = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/wpot_regbank.sv
module wpot_regbank
    import wpot_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_VALUE  = 8'hD0,
    parameter logic [BYTE_W-1:0] MAIN_INIT = 8'h80,
    parameter logic [BYTE_W-1:0] GP_INIT   = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wp_n,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic              wr_ack,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] wiper
);
    logic [BYTE_W-1:0]             ivr_q, wiper_q;
    logic [NUM_GP-1:0][BYTE_W-1:0] gp_q;
    logic [NUM_GP-1:0]             gp_we;
    logic                          vol_q;
    wr_plan_t                      plan;

    assign plan   = plan_write(wr_addr, wr_data, vol_q, wp_n);
    assign wr_ack = plan.ack;
    assign wiper  = wiper_q;

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_sel
        assign gp_we[g] = wr_stb && plan.wr_gp && (wr_addr == PTR_W'(int'(A_GP_FIRST) + g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ivr_q   <= MAIN_INIT;
            wiper_q <= MAIN_INIT;
            vol_q   <= 1'b0;
            gp_q    <= {NUM_GP{GP_INIT}};
        end else begin
            if (wr_stb && plan.wr_wiper) wiper_q <= wr_data;
            if (wr_stb && plan.wr_ivr)   ivr_q   <= wr_data;
            if (wr_stb && plan.wr_vol)   vol_q   <= wr_data[BYTE_W-1];
            for (int i = 0; i < NUM_GP; i++)
                if (gp_we[i]) gp_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '1;
        if (rd_addr == A_MAIN)      rd_data = vol_q ? wiper_q : ivr_q;
        else if (rd_addr == A_ID)   rd_data = ID_VALUE;
        else if (rd_addr == A_CTRL) rd_data = {vol_q, {(BYTE_W-1){1'b0}}};
        else begin
            for (int i = 0; i < NUM_GP; i++)
                if (rd_addr == PTR_W'(int'(A_GP_FIRST) + i)) rd_data = gp_q[i];
        end
    end

    // R10: write protect keeps storage registers untouched
    a_r10_wp_guards_nv: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wp_n && (wr_addr != A_CTRL) && !(wr_addr == A_MAIN && vol_q))
        |=> ($stable(gp_q) && $stable(ivr_q)));

    // R6: identification address accepts writes without effect
    a_r6_id_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == A_ID)
        |=> ($stable(gp_q) && $stable(ivr_q) && $stable(wiper_q) && $stable(vol_q)));

    // R5: volatile mapping leaves the start-up register alone
    a_r5_volatile_leaves_ivr: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == A_MAIN && vol_q) |=> $stable(ivr_q));

    // R4: bit 7 of any control byte is loaded
    a_r4_ctrl_takes_bit7: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == A_CTRL) |=> (vol_q == $past(wr_data[BYTE_W-1])));

endmodule

// File: rtl/wpot_i2c_slave.sv
module wpot_i2c_slave
    import wpot_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h28,
    parameter logic [BYTE_W-1:0] ID_VALUE    = 8'hD0,
    parameter logic [BYTE_W-1:0] MAIN_INIT   = 8'h80,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              busy_i,
    input  logic              wp_n_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] wiper_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t        st_q, nxt_q, dec_next;
    rx_kind_t          kind_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] sh_q, tx_q, rx_byte, rd_data;
    logic [PTR_W-1:0]  ptr_q;
    logic              ack_q, slot_q, last_q, mack_q, sda_oe_q;
    logic              byte_done, wr_stb, wr_ack, dec_ack;

    wpot_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign rx_byte   = {sh_q[BYTE_W-2:0], sda_lvl};
    assign byte_done = (st_q == S_RX) && scl_rise && (bit_q == 3'd7);
    assign wr_stb    = byte_done && (kind_q == K_DATA);

    wpot_regbank #(.ID_VALUE(ID_VALUE), .MAIN_INIT(MAIN_INIT)) u_bank (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(ptr_q), .wr_data(rx_byte),
        .wp_n(wp_n_i), .rd_addr(ptr_q), .wr_ack(wr_ack), .rd_data(rd_data), .wiper(wiper_o)
    );

    always_comb begin
        dec_ack  = 1'b0;
        dec_next = S_IGNORE;
        case (kind_q)
            K_DEV: if (rx_byte[BYTE_W-1:1] == DEV_ADDR && !busy_i) begin
                dec_ack  = 1'b1;
                dec_next = rx_byte[0] ? S_TX : S_RX;
            end
            K_MEM: if (addr_ok(rx_byte)) begin
                dec_ack  = 1'b1;
                dec_next = S_RX;
            end
            default: if (wr_ack) begin
                dec_ack  = 1'b1;
                dec_next = S_RX;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE; nxt_q <= S_IGNORE; kind_q <= K_DEV;
            bit_q <= '0; sh_q <= '0; tx_q <= '0; ptr_q <= '0;
            ack_q <= 1'b0; slot_q <= 1'b0; last_q <= 1'b0; mack_q <= 1'b0; sda_oe_q <= 1'b0;
        end else if (start_det) begin
            st_q <= S_RX; kind_q <= K_DEV; bit_q <= '0; sda_oe_q <= 1'b0;
        end else if (stop_det) begin
            st_q <= S_IDLE; sda_oe_q <= 1'b0;
        end else begin
            case (st_q)
                S_RX: if (scl_rise) begin
                    sh_q  <= rx_byte;
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        st_q   <= S_ACK;
                        slot_q <= 1'b0;
                        ack_q  <= dec_ack;
                        nxt_q  <= dec_next;
                        if (kind_q == K_MEM && dec_ack)  ptr_q <= rx_byte[PTR_W-1:0];
                        if (kind_q == K_DATA && dec_ack) ptr_q <= next_ptr(ptr_q);
                        kind_q <= (kind_q == K_DEV) ? K_MEM : K_DATA;
                    end
                end
                S_ACK: if (scl_fall) begin
                    if (!slot_q) begin
                        slot_q   <= 1'b1;
                        sda_oe_q <= ack_q;
                    end else begin
                        st_q  <= nxt_q;
                        bit_q <= '0;
                        if (nxt_q == S_TX) begin
                            tx_q     <= rd_data;
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                            last_q   <= 1'b0;
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) last_q <= 1'b1;
                    end
                    if (scl_fall) begin
                        if (last_q) begin
                            sda_oe_q <= 1'b0;
                            last_q   <= 1'b0;
                            st_q     <= S_MACK;
                            ptr_q    <= next_ptr(ptr_q);
                        end else begin
                            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                            sda_oe_q <= ~tx_q[BYTE_W-2];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) mack_q <= ~sda_lvl;
                    if (scl_fall) begin
                        if (mack_q) begin
                            st_q     <= S_TX;
                            bit_q    <= '0;
                            tx_q     <= rd_data;
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            st_q <= S_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = sda_oe_q;

    // R13: output enable is quiet while SCL stays high
    a_r13_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (rst)
        ($past(scl_lvl) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_q));

    // R1: nothing is driven while the bus is idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE) |-> !sda_oe_q);

    // R2: a busy sequencer refuses the device address
    a_r2_busy_refuses: assert property (@(posedge clk) disable iff (rst)
        (byte_done && kind_q == K_DEV && busy_i) |=> !ack_q);

    // R8: the pointer never leaves the register map
    a_r8_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= A_CTRL);

endmodule

// File: tb/wpot_i2c_slave_tb.sv
module wpot_i2c_slave_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bscl = 1'b1, bsda = 1'b1;
    logic busy = 1'b0, wp_n = 1'b1;
    logic sda_oe;
    logic [7:0] wiper;
    logic sda_w;
    int n_tests = 0, n_fail = 0, r13_viol = 0;
    logic done = 1'b0;
    logic ack_dev, ack_mem, ack_d0, ack_d1;
    logic [7:0] rd_buf [4];
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    always #10 clk = ~clk;

    assign sda_w = bsda & ~sda_oe;

    wpot_i2c_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(bscl), .sda_i(sda_w), .busy_i(busy),
        .wp_n_i(wp_n), .sda_oe_o(sda_oe), .wiper_o(wiper)
    );

    always @(negedge clk) begin
        if (!rst && bscl && prev_scl && (sda_oe != prev_oe)) r13_viol++;
        prev_scl <= bscl;
        prev_oe  <= sda_oe;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start();
        bsda = 1'b1; w(4); bscl = 1'b1; w(8); bsda = 1'b0; w(8); bscl = 1'b0; w(4);
    endtask

    task automatic bus_stop();
        bsda = 1'b0; w(4); bscl = 1'b1; w(8); bsda = 1'b1; w(8);
    endtask

    task automatic send_bit(input logic b);
        bsda = b; w(4); bscl = 1'b1; w(8); bscl = 1'b0; w(4);
    endtask

    task automatic recv_bit(output logic b);
        bsda = 1'b1; w(4); bscl = 1'b1; w(4); b = sda_w; w(4); bscl = 1'b0; w(4);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(!mack);
    endtask

    task automatic write_regs(input logic [7:0] a, input int n, input logic [7:0] d0,
                              input logic [7:0] d1);
        ack_d0 = 1'b0; ack_d1 = 1'b0;
        bus_start();
        write_byte(8'h50, ack_dev);
        write_byte(a, ack_mem);
        write_byte(d0, ack_d0);
        if (n > 1) write_byte(d1, ack_d1);
        bus_stop();
    endtask

    task automatic read_regs(input logic [7:0] a, input int n);
        logic ak;
        bus_start();
        write_byte(8'h50, ack_dev);
        write_byte(a, ack_mem);
        bus_start();
        write_byte(8'h51, ak);
        for (int i = 0; i < n; i++) read_byte(i < n - 1, rd_buf[i]);
        bus_stop();
    endtask

    task automatic read_cur(input int n);
        logic ak;
        bus_start();
        write_byte(8'h51, ak);
        for (int i = 0; i < n; i++) read_byte(i < n - 1, rd_buf[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R12 wiper after reset", wiper, 8'h80);
        check("R12 sda released after reset", {7'd0, sda_oe}, 8'h00);
        read_regs(8'h00, 1);
        check("R12 start-up register after reset", rd_buf[0], 8'h80);
        read_regs(8'h08, 1);
        check("R12 control flag after reset", rd_buf[0], 8'h00);
    endtask

    task automatic t_dev_addr();
        logic ak;
        bus_start(); write_byte(8'h52, ak); bus_stop();
        check("R1 foreign address refused", {7'd0, ak}, 8'h00);
        bus_start(); write_byte(8'h50, ak); bus_stop();
        check("R1 own write address accepted", {7'd0, ak}, 8'h01);
        check("R1 idle sda released", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_mem_range();
        write_regs(8'h07, 1, 8'h00, 8'h00);
        check("R3 reserved address 07h refused", {7'd0, ack_mem}, 8'h00);
        write_regs(8'h09, 1, 8'h00, 8'h00);
        check("R3 address 09h refused", {7'd0, ack_mem}, 8'h00);
        write_regs(8'h08, 1, 8'h00, 8'h00);
        check("R3 address 08h accepted", {7'd0, ack_mem}, 8'h01);
    endtask

    task automatic t_ctrl();
        write_regs(8'h08, 1, 8'h80, 8'h00);
        check("R4 legal 80h acknowledged", {7'd0, ack_d0}, 8'h01);
        read_regs(8'h08, 1);
        check("R4 flag reads 80h", rd_buf[0], 8'h80);
        write_regs(8'h08, 1, 8'h01, 8'h00);
        check("R4 illegal 01h refused", {7'd0, ack_d0}, 8'h00);
        read_regs(8'h08, 1);
        check("R4 flag cleared by bit 7 of 01h", rd_buf[0], 8'h00);
        write_regs(8'h08, 1, 8'h81, 8'h00);
        check("R4 illegal 81h refused", {7'd0, ack_d0}, 8'h00);
        read_regs(8'h08, 1);
        check("R4 flag set by bit 7 of 81h", rd_buf[0], 8'h80);
        write_regs(8'h08, 1, 8'h00, 8'h00);
    endtask

    task automatic t_remap();
        write_regs(8'h00, 1, 8'h5A, 8'h00);
        check("R5 flag 0 write acknowledged", {7'd0, ack_d0}, 8'h01);
        check("R5 flag 0 write moves wiper", wiper, 8'h5A);
        write_regs(8'h08, 1, 8'h80, 8'h00);
        write_regs(8'h00, 1, 8'h33, 8'h00);
        check("R5 flag 1 write moves wiper", wiper, 8'h33);
        read_regs(8'h00, 1);
        check("R5 flag 1 read returns wiper", rd_buf[0], 8'h33);
        write_regs(8'h08, 1, 8'h00, 8'h00);
        read_regs(8'h00, 1);
        check("R5 flag 0 read returns start-up register", rd_buf[0], 8'h5A);
    endtask

    task automatic t_id();
        write_regs(8'h01, 1, 8'hFF, 8'h00);
        check("R6 id write acknowledged", {7'd0, ack_d0}, 8'h01);
        read_regs(8'h01, 1);
        check("R6 id reads D0h", rd_buf[0], 8'hD0);
    endtask

    task automatic t_gp_seq();
        read_regs(8'h05, 1);
        check("R7 general byte resets to 00h", rd_buf[0], 8'h00);
        write_regs(8'h02, 2, 8'h11, 8'h22);
        check("R8 second written byte acknowledged", {7'd0, ack_d1}, 8'h01);
        read_regs(8'h02, 2);
        check("R7 general byte 02h", rd_buf[0], 8'h11);
        check("R8 auto-increment write reached 03h", rd_buf[1], 8'h22);
        read_regs(8'h06, 4);
        check("R7 reserved slot reads FFh", rd_buf[1], 8'hFF);
        check("R8 read reaches 08h", rd_buf[2], 8'h00);
        check("R8 pointer wraps to 00h", rd_buf[3], 8'h5A);
    endtask

    task automatic t_cur_read();
        read_regs(8'h02, 1);
        read_cur(1);
        check("R9 current read continues at 03h", rd_buf[0], 8'h22);
        read_cur(1);
        check("R9 second current read at 04h", rd_buf[0], 8'h00);
    endtask

    task automatic t_busy();
        logic ak;
        busy = 1'b1;
        bus_start(); write_byte(8'h50, ak); bus_stop();
        check("R2 busy refuses own address", {7'd0, ak}, 8'h00);
        busy = 1'b0;
        bus_start(); write_byte(8'h50, ak); bus_stop();
        check("R2 idle sequencer accepts address", {7'd0, ak}, 8'h01);
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        write_regs(8'h04, 1, 8'h77, 8'h00);
        check("R10 protected general byte refused", {7'd0, ack_d0}, 8'h00);
        read_regs(8'h04, 1);
        check("R10 protected general byte kept", rd_buf[0], 8'h00);
        write_regs(8'h08, 1, 8'h80, 8'h00);
        check("R10 control flag writable under protect", {7'd0, ack_d0}, 8'h01);
        write_regs(8'h00, 1, 8'h44, 8'h00);
        check("R10 wiper writable under protect", wiper, 8'h44);
        write_regs(8'h08, 1, 8'h00, 8'h00);
        write_regs(8'h00, 1, 8'h99, 8'h00);
        check("R10 protected start-up write refused", {7'd0, ack_d0}, 8'h00);
        check("R10 wiper unchanged by refused write", wiper, 8'h44);
        wp_n = 1'b1;
        read_regs(8'h00, 1);
        check("R10 start-up register kept", rd_buf[0], 8'h5A);
    endtask

    task automatic t_ignore();
        write_regs(8'h08, 1, 8'h80, 8'h00);
        write_regs(8'h08, 2, 8'h81, 8'h00);
        check("R11 byte after refusal not acknowledged", {7'd0, ack_d1}, 8'h00);
        read_regs(8'h08, 1);
        check("R11 byte after refusal dropped", rd_buf[0], 8'h80);
        check("R11 wiper untouched", wiper, 8'h44);
        check("R11 sda released after host no-ack", {7'd0, sda_oe}, 8'h00);
        write_regs(8'h08, 1, 8'h00, 8'h00);
    endtask

    initial begin
        w(6);
        rst = 1'b0;
        w(6);
        t_reset();
        t_dev_addr();
        t_mem_range();
        t_ctrl();
        t_remap();
        t_id();
        t_gp_seq();
        t_cur_read();
        t_busy();
        t_wp();
        t_ignore();
        check("R13 enable steady while SCL high", r13_viol[7:0], 8'h00);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule